// File: doc/BRIEF.md
# Oscillator Loss Fallback Clock Selector

This block decides which source drives the system clock: the external oscillator, the PLL, or a free-running internal self-clock. It watches a loss indication for the oscillator clock. When both the monitor enable and the self-clock enable are set, a loss moves the system onto the self-clock and forces the PLL-select bit clear. When the oscillator is reported stable again, the block goes back to the oscillator by itself. It does not go back to the PLL. Software has to select the PLL again once normal operation has resumed.

If the monitor is enabled but the self-clock fallback is not, a loss raises a monitor reset request instead of switching sources. If the monitor is disabled, no loss is seen at all. A system that runs straight off the oscillator is then reported as static, and a system on the PLL simply keeps that selection.

All control inputs are sampled on the block clock. Every state change is taken only in cycles where the step enable is high, so the select output moves only on enable boundaries. The stable indication is a single-cycle input standing in for the quality check. The asynchronous reset is released through a synchronizer inside the block.

Top module: `clk_fallback_ctrl`

## Requirements
- R1: In normal mode, a step cycle with `osc_lost`, `mon_en` and `scm_en` all 1 enters self-clock mode: from the next cycle `scm_active`=1 and `src_sel`=2'b10.
- R2: On entry to self-clock mode `pll_sel` becomes 0, whatever its value before.
- R3: In self-clock mode, a step cycle with `osc_good`=1 returns to normal mode with `src_sel`=2'b00 and `pll_sel`=0, even if `osc_lost` is also 1.
- R4: With `mon_en`=0 a loss causes no entry and no monitor reset request; with `pll_sel`=1 `src_sel` stays 2'b01.
- R5: In normal mode, a step cycle with `mon_en`=0, `osc_lost`=1 and `pll_sel`=0 sets `clk_static`=1 from the next cycle; any later step cycle without that condition clears it.
- R6: In normal mode, a step cycle with `osc_lost`=1, `mon_en`=1 and `scm_en`=0 gives a one-cycle `mon_rst_req` pulse in the next cycle and leaves `src_sel` unchanged.
- R7: In normal mode, a step cycle with `pll_wr`=1 loads `pll_val` into `pll_sel`, and `src_sel` then reads 2'b01 for 1 and 2'b00 for 0. In self-clock mode such writes are ignored.
- R8: `scm_enter_p` and `scm_exit_p` are each high for exactly the one cycle after the step that enters or leaves self-clock mode.
- R9: In a cycle with `step_en`=0 nothing changes: `src_sel`, `pll_sel`, `scm_active` and `clk_static` hold, and every pulse output is 0 in the next cycle.
- R10: After reset `src_sel`=2'b00 and every other output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_en | input | 1 | Clock enable; state changes only when high |
| osc_lost | input | 1 | Oscillator clock loss indication |
| osc_good | input | 1 | Oscillator reported stable again (pulse) |
| mon_en | input | 1 | Clock monitor enable |
| scm_en | input | 1 | Self-clock fallback enable |
| pll_wr | input | 1 | Software write strobe for the PLL-select bit |
| pll_val | input | 1 | Value written to the PLL-select bit |
| src_sel | output | 2 | Clock source: 00 oscillator, 01 PLL, 10 self-clock |
| pll_sel | output | 1 | PLL-select status bit |
| scm_active | output | 1 | Self-clock mode active |
| clk_static | output | 1 | System clock is static (unmonitored loss on oscillator) |
| mon_rst_req | output | 1 | Monitor reset request pulse |
| scm_enter_p | output | 1 | Pulse on entry into self-clock mode |
| scm_exit_p | output | 1 | Pulse on exit from self-clock mode |

## Verification
The assertions check every cycle that entry into self-clock mode happens only after both enables were set, and that the PLL bit is clear for as long as self-clock mode lasts. They also check that exit follows a stable indication in a step cycle, that nothing changes in cycles without a step, and that the pulses line up with mode changes. The bench's scenarios cover what a single property cannot show. Examples are a PLL write that is dropped in self-clock mode and then accepted after exit, the return to the oscillator and not to the PLL, the static report, and the repeated monitor reset pulses while a loss persists without fallback.

// File: rtl/clk_fallback_pkg.sv
package clk_fallback_pkg;
  localparam int SEL_W = 2;
  localparam int EVT_N = 3;

  typedef enum logic [SEL_W-1:0] {
    SRC_OSC  = 2'b00,
    SRC_PLL  = 2'b01,
    SRC_SELF = 2'b10
  } src_e;

  // event index into the pulse vector
  localparam int EVT_ENTER = 0;
  localparam int EVT_EXIT  = 1;
  localparam int EVT_MRST  = 2;
endpackage

// File: rtl/cfb_rst_sync.sv
module cfb_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= 1'b0;
          else        chain_q[g] <= 1'b1;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= 1'b0;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/cfb_mode_fsm.sv
module cfb_mode_fsm
  import clk_fallback_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_en,
  input  logic             osc_lost,
  input  logic             osc_good,
  input  logic             mon_en,
  input  logic             scm_en,
  input  logic             pll_wr,
  input  logic             pll_val,
  output logic             scm_q,
  output logic             pll_q,
  output logic             scm_d,
  output logic             pll_d,
  output logic             static_d,
  output logic [EVT_N-1:0] evt_d
);
  always_comb begin
    scm_d    = scm_q;
    pll_d    = pll_q;
    evt_d    = '0;
    static_d = !scm_q && !mon_en && osc_lost && !pll_q;
    if (step_en) begin
      if (scm_q) begin
        // writes to the PLL bit are dropped here
        if (osc_good) begin
          scm_d            = 1'b0;
          evt_d[EVT_EXIT]  = 1'b1;
        end
      end else if (osc_lost && mon_en && scm_en) begin
        scm_d            = 1'b1;
        pll_d            = 1'b0;
        evt_d[EVT_ENTER] = 1'b1;
      end else begin
        if (osc_lost && mon_en) evt_d[EVT_MRST] = 1'b1;
        if (pll_wr)             pll_d = pll_val;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scm_q <= 1'b0;
      pll_q <= 1'b0;
    end else if (step_en) begin
      scm_q <= scm_d;
      pll_q <= pll_d;
    end
  end
endmodule

// File: rtl/cfb_src_reg.sv
module cfb_src_reg
  import clk_fallback_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_en,
  input  logic             scm_d,
  input  logic             pll_d,
  input  logic             static_d,
  output logic [SEL_W-1:0] src_sel,
  output logic             clk_static
);
  src_e src_d, src_q;
  logic static_q;

  always_comb begin
    if (scm_d)      src_d = SRC_SELF;
    else if (pll_d) src_d = SRC_PLL;
    else            src_d = SRC_OSC;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q    <= SRC_OSC;
      static_q <= 1'b0;
    end else if (step_en) begin
      src_q    <= src_d;
      static_q <= static_d;
    end
  end

  assign src_sel    = src_q;
  assign clk_static = static_q;
endmodule

// File: rtl/cfb_event_reg.sv
module cfb_event_reg
  import clk_fallback_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [EVT_N-1:0] evt_d,
  output logic [EVT_N-1:0] evt_q
);
  genvar g;
  generate
    for (g = 0; g < EVT_N; g++) begin : g_evt
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) evt_q[g] <= 1'b0;
        else        evt_q[g] <= evt_d[g];
      end
    end
  endgenerate
endmodule

// File: rtl/clk_fallback_ctrl.sv
module clk_fallback_ctrl
  import clk_fallback_pkg::*;
#(
  parameter int RST_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_en,
  input  logic             osc_lost,
  input  logic             osc_good,
  input  logic             mon_en,
  input  logic             scm_en,
  input  logic             pll_wr,
  input  logic             pll_val,
  output logic [SEL_W-1:0] src_sel,
  output logic             pll_sel,
  output logic             scm_active,
  output logic             clk_static,
  output logic             mon_rst_req,
  output logic             scm_enter_p,
  output logic             scm_exit_p
);
  logic             rst_int_n;
  logic             scm_q, pll_q, scm_d, pll_d, static_d;
  logic [EVT_N-1:0] evt_d, evt_q;

  cfb_rst_sync #(.STAGES(RST_STAGES)) i_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_int_n)
  );

  cfb_mode_fsm i_fsm (
    .clk(clk), .rst_n(rst_int_n), .step_en(step_en),
    .osc_lost(osc_lost), .osc_good(osc_good), .mon_en(mon_en),
    .scm_en(scm_en), .pll_wr(pll_wr), .pll_val(pll_val),
    .scm_q(scm_q), .pll_q(pll_q), .scm_d(scm_d), .pll_d(pll_d),
    .static_d(static_d), .evt_d(evt_d)
  );

  cfb_src_reg i_src (
    .clk(clk), .rst_n(rst_int_n), .step_en(step_en),
    .scm_d(scm_d), .pll_d(pll_d), .static_d(static_d),
    .src_sel(src_sel), .clk_static(clk_static)
  );

  cfb_event_reg i_evt (
    .clk(clk), .rst_n(rst_int_n), .evt_d(evt_d), .evt_q(evt_q)
  );

  assign pll_sel     = pll_q;
  assign scm_active  = scm_q;
  assign scm_enter_p = evt_q[EVT_ENTER];
  assign scm_exit_p  = evt_q[EVT_EXIT];
  assign mon_rst_req = evt_q[EVT_MRST];
endmodule

// File: rtl/clk_fallback_chk.sv
module clk_fallback_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       step_en,
  input logic       osc_lost,
  input logic       osc_good,
  input logic       mon_en,
  input logic       scm_en,
  input logic [1:0] src_sel,
  input logic       pll_sel,
  input logic       scm_active,
  input logic       clk_static,
  input logic       mon_rst_req,
  input logic       scm_enter_p,
  input logic       scm_exit_p
);
  a_r1_entry_needs_enables: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scm_active) |-> $past(mon_en && scm_en && osc_lost && step_en));

  a_r1_self_select: assert property (@(posedge clk) disable iff (!rst_n)
    scm_active |-> src_sel == 2'b10);

  a_r2_pll_clear_in_self: assert property (@(posedge clk) disable iff (!rst_n)
    scm_active |-> !pll_sel);

  a_r3_exit_on_good: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(scm_active) |-> $past(osc_good && step_en) && src_sel == 2'b00);

  a_r4_no_reset_without_monitor: assert property (@(posedge clk) disable iff (!rst_n)
    mon_rst_req |-> $past(mon_en && osc_lost));

  a_r5_static_not_in_self: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({scm_active, clk_static}));

  a_r8_enter_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    scm_enter_p |-> scm_active && !$past(scm_active));

  a_r8_exit_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    scm_exit_p |-> !scm_active && $past(scm_active));

  a_r9_hold_without_step: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(step_en) |-> $stable(src_sel) && $stable(pll_sel) && $stable(clk_static)
                        && !scm_enter_p && !scm_exit_p && !mon_rst_req);
endmodule

bind clk_fallback_ctrl clk_fallback_chk i_chk (
  .clk(clk), .rst_n(rst_n), .step_en(step_en), .osc_lost(osc_lost),
  .osc_good(osc_good), .mon_en(mon_en), .scm_en(scm_en),
  .src_sel(src_sel), .pll_sel(pll_sel), .scm_active(scm_active),
  .clk_static(clk_static), .mon_rst_req(mon_rst_req),
  .scm_enter_p(scm_enter_p), .scm_exit_p(scm_exit_p)
);

// File: tb/test_clk_fallback_ctrl.sv
module test_clk_fallback_ctrl;
  localparam int CLK_P = 10;

  logic clk, rst_n, step_en, osc_lost, osc_good, mon_en, scm_en, pll_wr, pll_val;
  logic [1:0] src_sel;
  logic pll_sel, scm_active, clk_static, mon_rst_req, scm_enter_p, scm_exit_p;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  // behavioural reference state
  bit m_scm, m_pll, m_static, m_rst, m_ent, m_ext;
  int rst_cnt;

  clk_fallback_ctrl i_clk_fallback_ctrl (
    .clk(clk), .rst_n(rst_n), .step_en(step_en), .osc_lost(osc_lost),
    .osc_good(osc_good), .mon_en(mon_en), .scm_en(scm_en), .pll_wr(pll_wr),
    .pll_val(pll_val), .src_sel(src_sel), .pll_sel(pll_sel),
    .scm_active(scm_active), .clk_static(clk_static), .mon_rst_req(mon_rst_req),
    .scm_enter_p(scm_enter_p), .scm_exit_p(scm_exit_p)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  always @(posedge clk) begin
    bit in_rst, st;
    in_rst = (!rst_n) || (rst_cnt < 2);
    if (!rst_n) rst_cnt = 0;
    else if (rst_cnt < 2) rst_cnt++;
    m_ent = 0; m_ext = 0; m_rst = 0;
    if (in_rst) begin
      m_scm = 0; m_pll = 0; m_static = 0;
    end else if (step_en) begin
      st = !m_scm && !mon_en && osc_lost && !m_pll;
      if (m_scm) begin
        if (osc_good) begin m_scm = 0; m_ext = 1; end
      end else if (osc_lost && mon_en && scm_en) begin
        m_scm = 1; m_pll = 0; m_ent = 1;
      end else begin
        if (osc_lost && mon_en) m_rst = 1;
        if (pll_wr) m_pll = pll_val;
      end
      m_static = st;
    end
  end

  task automatic cmp(input string req, input string nm, input int act, input int exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, nm, act, exp, $time);
    end
  endtask

  task automatic check_all();
    int exp_src;
    exp_src = m_scm ? 2 : (m_pll ? 1 : 0);
    cmp("R1/R3/R7", "src_sel", src_sel, exp_src);
    cmp("R2/R7", "pll_sel", pll_sel, m_pll);
    cmp("R1/R3", "scm_active", scm_active, m_scm);
    cmp("R5", "clk_static", clk_static, m_static);
    cmp("R6/R4", "mon_rst_req", mon_rst_req, m_rst);
    cmp("R8", "scm_enter_p", scm_enter_p, m_ent);
    cmp("R8", "scm_exit_p", scm_exit_p, m_ext);
  endtask

  // drive one cycle: check outputs of the previous edge, then apply inputs
  task automatic cyc(input bit st, input bit lo, input bit gd, input bit me,
                     input bit se, input bit wr, input bit val);
    @(negedge clk);
    check_all();
    step_en = st; osc_lost = lo; osc_good = gd; mon_en = me;
    scm_en = se; pll_wr = wr; pll_val = val;
  endtask

  initial begin
    #(CLK_P*100000);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    rst_n = 0; rst_cnt = 0;
    step_en = 0; osc_lost = 0; osc_good = 0; mon_en = 0; scm_en = 0; pll_wr = 0; pll_val = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    repeat (3) cyc(0, 0, 0, 0, 0, 0, 0);
    // R10 reset values
    @(negedge clk);
    cmp("R10", "src_sel reset", src_sel, 0);
    cmp("R10", "pll_sel reset", pll_sel, 0);
    // R7 select PLL in normal mode
    cyc(1, 0, 0, 1, 1, 1, 1);
    cyc(0, 0, 0, 1, 1, 0, 0);
    // R9 loss without step: nothing happens
    cyc(0, 1, 0, 1, 1, 0, 0);
    cyc(0, 0, 0, 1, 1, 0, 0);
    // R1 R2 entry from PLL clears pll bit
    cyc(1, 1, 0, 1, 1, 0, 0);
    cyc(1, 1, 0, 1, 1, 0, 0);
    // R7 write ignored in self mode
    cyc(1, 1, 0, 1, 1, 1, 1);
    cyc(1, 0, 0, 1, 1, 0, 0);
    // R3 exit on good even with loss; returns to oscillator
    cyc(1, 1, 1, 1, 1, 0, 0);
    cyc(1, 0, 0, 1, 1, 0, 0);
    cyc(1, 0, 0, 1, 1, 0, 0);
    // R6 monitor reset without fallback, repeated while loss persists
    cyc(1, 1, 0, 1, 0, 0, 0);
    cyc(1, 1, 0, 1, 0, 0, 0);
    cyc(1, 0, 0, 1, 0, 0, 0);
    // R5 static on oscillator with monitor off
    cyc(1, 1, 0, 0, 1, 0, 0);
    cyc(0, 1, 0, 0, 1, 0, 0);
    cyc(1, 0, 0, 0, 1, 0, 0);
    // R4 monitor off while on PLL: loss undetected
    cyc(1, 0, 0, 0, 0, 1, 1);
    cyc(1, 1, 0, 0, 1, 0, 0);
    cyc(1, 1, 0, 0, 1, 0, 0);
    cyc(1, 0, 0, 0, 0, 1, 0);
    // R8 R9 mixed patterns
    for (int i = 0; i < 400; i++) begin
      int r;
      r = $urandom;
      cyc(r[0] | r[1], r[2] & r[3], r[4] & r[5], r[6] | r[7], r[8], r[9] & r[10], r[11]);
    end
    cyc(0, 0, 0, 0, 0, 0, 0);
    @(negedge clk);
    check_all();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule